// File: doc/BRIEF.md
# Fixed-Priority Shared Resource Arbiter with Selectable Preemption

This block hands out one shared resource, one clock cycle (time unit) at a time, among `N` masters. A master starts a job with a one-cycle start strobe. With the strobe it gives a job length, which is the number of time units it needs. It also drives a static priority value, where smaller numbers mean more urgent and 1 is the most urgent. The block keeps a remaining-unit counter for every master. Each cycle it raises at most one grant bit, and it raises a finish flag during the last unit of a job.

A mode input picks one of two policies. In run-to-completion mode, a master that holds the resource keeps it until its job is fully served. In preemptive mode, a newly started job with a strictly smaller priority value takes the resource on the following cycle. The interrupted master keeps its remaining count and later continues from that count. It does not restart its job. The mode is latched only in cycles where nothing is granted, so a policy change never lands in the middle of a service sequence.

Top module: `prio_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `gnt` and `fin` are all zero.
- R2: In every cycle at most one bit of `gnt` is set.
- R3: While any master has an unfinished job, some master is granted. The resource is never idle while work is pending.
- R4: When no holder is kept, the grant goes to the pending master with the smallest `rq_prio` value. Among equal values, the lowest master index wins.
- R5: In preemptive mode (latched `mode_preempt` = 1), a master with a strictly smaller priority value than the holder gets the grant in the cycle after its start strobe.
- R6: In preemptive mode, a newly started job with an equal or larger priority value does not take the grant from the current holder.
- R7: In run-to-completion mode (latched `mode_preempt` = 0), a granted master stays granted in consecutive cycles until its whole length is served. Arrivals with smaller priority values wait.
- R8: A preempted master resumes from its remaining count. Over a job, a master is granted in exactly `rq_len` cycles in total.
- R9: `fin[i]` is high only during the last granted unit of master i's job, once per job. `gnt[i]` is low in the next cycle.
- R10: `mode_preempt` is latched only at clock edges that end a cycle with no grant. A change made while a master is granted has no effect until the resource goes idle.
- R11: A start strobe is ignored while that master still has an unfinished job. A start strobe with `rq_len` = 0 is ignored.
- R12: A start strobe is taken at the clock edge that ends its cycle. The earliest grant for that job is in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one time unit |
| rst | input | 1 | Synchronous active-high reset |
| rq_start | input | N | Per-master one-cycle job start strobe |
| rq_prio | input | N*PW | Per-master priority value, master i at bits [i*PW +: PW]; 1 is most urgent |
| rq_len | input | N*LW | Per-master job length in units, master i at bits [i*LW +: LW] |
| mode_preempt | input | 1 | 1 = preemptive, 0 = run-to-completion; latched only while idle |
| gnt | output | N | One-hot (or zero) grant for the current time unit |
| fin | output | N | High during the final granted unit of a master's job |

## Verification
The properties assume that every master's priority value is at least 1. They also assume the value stays steady while that master has a job pending, because the selection compares live priority inputs each cycle. The bench drives each master's priority together with its start strobe and does not change it until the job has finished, and it only uses values from 1 to 4. The bench changes the mode input only while the resource is idle, except in the one test that checks the mode input is ignored while a master holds the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        MODE_HOLD    = 1'b0,
        MODE_PREEMPT = 1'b1
    } arb_mode_e;

    // True when a new contender should displace the current holder.
    function automatic logic displaces(input arb_mode_e mode,
                                       input logic [15:0] cand_prio,
                                       input logic [15:0] hold_prio);
        return (mode == MODE_PREEMPT) && (cand_prio < hold_prio);
    endfunction

endpackage

// File: rtl/arb_len_counter.sv
module arb_len_counter #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic          serve,
    output logic          pend,
    output logic          last
);
    logic [LW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (remain_q == '0) begin
            if (start && len != '0)
                remain_q <= len;
        end else if (serve) begin
            remain_q <= remain_q - LW'(1);
        end
    end

    assign pend = (remain_q != '0);
    assign last = (remain_q == LW'(1));
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N  = 4,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   best_idx,
    output logic [PW-1:0]   best_prio
);
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || prio[i*PW +: PW] < best_prio)) begin
                found     = 1'b1;
                best_idx  = IW'(i);
                best_prio = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]    rq_start,
    input  logic [N*PW-1:0] rq_prio,
    input  logic [N*LW-1:0] rq_len,
    input  logic            mode_preempt,
    output logic [N-1:0]    gnt,
    output logic [N-1:0]    fin
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  pend;
    logic [N-1:0]  last;
    logic          found;
    logic [IW-1:0] best_idx;
    logic [PW-1:0] best_prio;
    logic [IW-1:0] sel_idx;
    logic [PW-1:0] hold_prio;

    logic          hold_vld_q;
    logic [IW-1:0] hold_idx_q;
    arb_mode_e     mode_q;

    for (genvar g = 0; g < N; g++) begin : g_ctr
        arb_len_counter #(.LW(LW)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .start (rq_start[g]),
            .len   (rq_len[g*LW +: LW]),
            .serve (gnt[g]),
            .pend  (pend[g]),
            .last  (last[g])
        );
    end

    arb_prio_pick #(.N(N), .PW(PW)) u_pick (
        .elig      (pend),
        .prio      (rq_prio),
        .found     (found),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    assign hold_prio = rq_prio[hold_idx_q*PW +: PW];

    always_comb begin
        sel_idx = best_idx;
        if (hold_vld_q &&
            !displaces(mode_q, 16'(best_prio), 16'(hold_prio)))
            sel_idx = hold_idx_q;
    end

    always_comb begin
        gnt = '0;
        if (found)
            gnt[sel_idx] = 1'b1;
    end

    assign fin = gnt & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld_q <= 1'b0;
            hold_idx_q <= '0;
            mode_q     <= MODE_HOLD;
        end else begin
            hold_vld_q <= |(gnt & ~last);
            hold_idx_q <= sel_idx;
            if (gnt == '0)
                mode_q <= arb_mode_e'(mode_preempt);
        end
    end
endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] gnt,
    input logic [N-1:0] fin,
    input logic [N-1:0] pend,
    input logic         mode_q
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R2

    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        (|pend) |-> (|gnt)); // R3

    AST_FIN_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
        ((fin & ~gnt) == '0)); // R9

    AST_FIN_THEN_DROP: assert property (@(posedge clk) disable iff (rst)
        (|fin) |=> ((gnt & $past(fin)) == '0)); // R9

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && |(gnt & ~fin)) |=> (gnt == $past(gnt))); // R7

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> (mode_q == $past(mode_q))); // R10
endmodule

bind prio_arbiter prio_arbiter_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .gnt    (gnt),
    .fin    (fin),
    .pend   (pend),
    .mode_q (mode_q)
);

// File: tb/prio_arbiter_tb.sv
module prio_arbiter_tb;
    localparam int N  = 4;
    localparam int PW = 3;
    localparam int LW = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    rq_start;
    logic [N*PW-1:0] rq_prio;
    logic [N*LW-1:0] rq_len;
    logic            mode_preempt;
    logic [N-1:0]    gnt;
    logic [N-1:0]    fin;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int units[N];
    int dones[N];
    int done_cyc[N];

    always #10 clk = ~clk;

    prio_arbiter #(.N(N), .PW(PW), .LW(LW)) u_dut (
        .clk(clk), .rst(rst), .rq_start(rq_start), .rq_prio(rq_prio),
        .rq_len(rq_len), .mode_preempt(mode_preempt), .gnt(gnt), .fin(fin)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) units[i]++;
            if (fin[i]) begin
                dones[i]++;
                done_cyc[i] = cyc;
            end
        end
        @(posedge clk);
        #5;
        cyc++;
    endtask

    task automatic clear_stats();
        cyc = 0;
        for (int i = 0; i < N; i++) begin
            units[i] = 0; dones[i] = 0; done_cyc[i] = -1;
        end
    endtask

    task automatic set_job(input int i, input int p, input int l);
        rq_prio[i*PW +: PW] = PW'(p);
        rq_len[i*LW +: LW]  = LW'(l);
    endtask

    task automatic pulse1(input int i, input int p, input int l);
        set_job(i, p, l);
        rq_start[i] = 1'b1;
        step();
        rq_start[i] = 1'b0;
    endtask

    task automatic pair_case(input bit m, input int a, input int b,
                             input int pa, input int pb);
        bit sw;
        mode_preempt = m;
        clear_stats();
        pulse1(a, pa, 6);
        chk(gnt == N'(1 << a), "R4 lone job granted", int'(gnt), 1 << a);
        step(); step();
        pulse1(b, pb, 3);
        sw = m && (pb < pa);
        if (sw)
            chk(gnt == N'(1 << b), "R5 higher arrival takes grant", int'(gnt), 1 << b);
        else if (m)
            chk(gnt == N'(1 << a), "R6 holder not displaced", int'(gnt), 1 << a);
        else
            chk(gnt == N'(1 << a), "R7 run-to-completion holds", int'(gnt), 1 << a);
        repeat (6) step();
        chk(gnt == '0, "R3 all work done in 9 units", int'(gnt), 0);
        chk(units[a] == 6 && dones[a] == 1, "R8 holder total units", units[a], 6);
        chk(units[b] == 3 && dones[b] == 1, "R8 arrival total units", units[b], 3);
        chk(done_cyc[a] == (sw ? 9 : 6), "R9 holder finish cycle", done_cyc[a], sw ? 9 : 6);
        chk(done_cyc[b] == (sw ? 6 : 9), "R9 arrival finish cycle", done_cyc[b], sw ? 6 : 9);
    endtask

    task automatic tie_case(input bit m, input int p0, input int p1,
                            input int p2, input int p3);
        int p[N];
        int rank;
        int first;
        p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
        mode_preempt = m;
        clear_stats();
        first = 0;
        for (int i = 0; i < N; i++) begin
            set_job(i, p[i], 2);
            if (p[i] < p[first]) first = i;
        end
        rq_start = '1;
        step();
        rq_start = '0;
        chk(gnt == N'(1 << first), "R4 smallest value lowest index first", int'(gnt), 1 << first);
        repeat (8) step();
        for (int i = 0; i < N; i++) begin
            rank = 0;
            for (int j = 0; j < N; j++)
                if (p[j] < p[i] || (p[j] == p[i] && j < i)) rank++;
            chk(done_cyc[i] == 2 * (rank + 1), "R4 service order", done_cyc[i], 2 * (rank + 1));
        end
        chk(gnt == '0, "R3 idle after all served", int'(gnt), 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; rq_start = '0; rq_prio = '0; rq_len = '0; mode_preempt = 1'b0;
        clear_stats();
        repeat (3) @(posedge clk);
        #5;
        chk(gnt == '0 && fin == '0, "R1 outputs idle in reset", int'(gnt), 0);
        rst = 1'b0;
        step();
        chk(gnt == '0 && fin == '0, "R1 outputs idle after reset", int'(gnt), 0);

        // single-master length sweep
        for (int i = 0; i < N; i++) begin
            for (int l = 1; l < 16; l++) begin
                clear_stats();
                chk(gnt == '0, "R12 no grant before strobe", int'(gnt), 0);
                pulse1(i, 3, l);
                chk(gnt == N'(1 << i), "R12 grant the cycle after strobe", int'(gnt), 1 << i);
                repeat (l) step();
                chk(units[i] == l && dones[i] == 1, "R7 contiguous units", units[i], l);
                chk(done_cyc[i] == l, "R9 finish on last unit", done_cyc[i], l);
                chk(gnt == '0, "R9 grant gone after finish", int'(gnt), 0);
            end
        end

        // pairwise arrival sweep, both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    if (a != b)
                        for (int pa = 1; pa <= 4; pa++)
                            for (int pb = 1; pb <= 4; pb++)
                                pair_case(m[0], a, b, pa, pb);

        // simultaneous arrivals
        for (int m = 0; m < 2; m++) begin
            tie_case(m[0], 3, 1, 1, 2);
            tie_case(m[0], 2, 2, 2, 2);
            tie_case(m[0], 4, 3, 2, 1);
            tie_case(m[0], 1, 4, 1, 4);
        end

        // mode change while busy is not taken
        mode_preempt = 1'b0;
        step();
        clear_stats();
        pulse1(0, 4, 6);
        mode_preempt = 1'b1;
        step(); step();
        pulse1(1, 1, 2);
        chk(gnt == N'(1), "R10 mode change ignored while granted", int'(gnt), 1);
        repeat (5) step();
        chk(done_cyc[1] == 8 && gnt == '0, "R10 old mode kept to the end", done_cyc[1], 8);
        clear_stats();
        pulse1(0, 4, 6);
        step(); step();
        pulse1(1, 1, 2);
        chk(gnt == N'(2), "R10 new mode taken after idle", int'(gnt), 2);
        repeat (7) step();
        chk(gnt == '0, "R3 idle after mode test", int'(gnt), 0);

        // strobes that must be ignored
        clear_stats();
        pulse1(2, 2, 3);
        step();
        pulse1(2, 2, 9);
        repeat (3) step();
        chk(units[2] == 3 && dones[2] == 1, "R11 restrobe while busy ignored", units[2], 3);
        chk(gnt == '0, "R11 no extra job queued", int'(gnt), 0);
        clear_stats();
        pulse1(3, 1, 0);
        chk(gnt == '0 && fin == '0, "R11 zero length ignored", int'(gnt), 0);
        step();
        chk(units[3] == 0 && dones[3] == 0, "R11 zero length never served", units[3], 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule